// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block raises and drops the port-to-port interrupts of a two-port shared memory of 8K 16-bit words. It sits beside the memory array, where it can see each port's access strobe, address, write control and busy input. It drives one active-low interrupt line to each port. The message words themselves are held in the ordinary array. This block keeps only one pending flag per port.

The two top words of the address space act as mailboxes. The topmost word, 0x1FFF, belongs to the right port. The word just below it, 0x1FFE, belongs to the left port. When a port writes into the mailbox of the other port, the owner's interrupt goes active. When the owner later reads its own mailbox, the interrupt goes inactive again. A port whose busy input is high loses both abilities for that cycle: its write cannot raise the peer's interrupt, and its read cannot clear its own.

All inputs are sampled on the rising clock edge. An interrupt output changes in the cycle after the access that causes the change.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no access, both `l_irq_n` and `r_irq_n` are 1 (inactive).
- R2: A left access with `l_sel`=1, `l_we`=1, `l_addr`=0x1FFF and `l_busy`=0 drives `r_irq_n` to 0 after the next clock edge.
- R3: A right access with `r_sel`=1, `r_we`=1, `r_addr`=0x1FFE and `r_busy`=0 drives `l_irq_n` to 0 after the next clock edge.
- R4: An owner read (`sel`=1, `we`=0) of its own mailbox with its busy at 0 returns that owner's interrupt to 1 after the next edge. The left port's mailbox is 0x1FFE and the right port's mailbox is 0x1FFF.
- R5: A port reading the other port's mailbox leaves both interrupts unchanged.
- R6: A mailbox write made while the writer's busy is 1 does not raise the peer's interrupt.
- R7: An owner read of its own mailbox made while the owner's busy is 1 does not clear its interrupt.
- R8: When a raise and a clear of the same interrupt happen in the same cycle, the interrupt ends up active (0).
- R9: An owner writing its own mailbox neither raises nor clears its interrupt.
- R10: Accesses with `sel`=0, and accesses to any address other than the two mailboxes, leave both interrupts unchanged.
- R11: Between a raise and a clear, an interrupt stays active across idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left port access strobe |
| l_we | input | 1 | Left port write (1) or read (0) |
| l_addr | input | 13 | Left port word address |
| l_busy | input | 1 | Left port busy, active high |
| r_sel | input | 1 | Right port access strobe |
| r_we | input | 1 | Right port write (1) or read (0) |
| r_addr | input | 13 | Right port word address |
| r_busy | input | 1 | Right port busy, active high |
| l_irq_n | output | 1 | Interrupt to the left port, active low |
| r_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
The assertions assume the port inputs are stable and known at every rising edge. They also assume that each busy signal is meaningful only together with that port's own strobe, so a falling interrupt can always be traced to a non-busy peer write in the previous cycle. The bench drives every input at the falling edge, so each value is settled a half period before it is sampled. It holds each access for exactly one cycle, so every expected value belongs to a single edge. The simultaneous-access cases put both ports on a mailbox in the same cycle on purpose, to test the priority of a raise over a clear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic {
      SIDE_L = 1'b0,
      SIDE_R = 1'b1
   } side_e;

   typedef struct packed {
      logic sel;
      logic we;
      logic busy;
   } acc_ctl_t;

   function automatic int unsigned peer_of(input int unsigned side);
      return (side == 0) ? 1 : 0;
   endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
   parameter int unsigned ADDR_W    = 13,
   parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
   parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
   input  mbx_pkg::acc_ctl_t ctl_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              raise_peer_o,
   output logic              drop_own_o
);

   generate
      if (OWN_BOX == PEER_BOX) begin : g_bad_boxes
         $error("mbx_decode: the two mailbox addresses must differ");
      end
   endgenerate

   logic live;
   logic hit_own;
   logic hit_peer;

   always_comb begin
      live     = ctl_i.sel && !ctl_i.busy;
      hit_own  = (addr_i == OWN_BOX);
      hit_peer = (addr_i == PEER_BOX);
      raise_peer_o = live &&  ctl_i.we && hit_peer;
      drop_own_o   = live && !ctl_i.we && hit_own;
   end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic raise_i,
   input  logic drop_i,
   output logic irq_n_o
);

   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (raise_i)
         pend_q <= 1'b1;
      else if (drop_i)
         pend_q <= 1'b0;
   end

   assign irq_n_o = !pend_q;

   // R8
   raise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      raise_i |=> !irq_n_o);

   // R4
   drop_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_i && !raise_i) |=> irq_n_o);

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!raise_i && !drop_i) |=> $stable(irq_n_o));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl #(
   parameter int unsigned ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel,
   input  logic              l_we,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_busy,
   input  logic              r_sel,
   input  logic              r_we,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_busy,
   output logic              l_irq_n,
   output logic              r_irq_n
);

   import mbx_pkg::*;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("mbx_irq_ctrl: ADDR_W must be at least 2");
      end
   endgenerate

   localparam int unsigned NSIDE = 2;
   localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

   acc_ctl_t          ctl   [NSIDE];
   logic [ADDR_W-1:0] addr  [NSIDE];
   logic [NSIDE-1:0]  raise_from;
   logic [NSIDE-1:0]  drop_of;
   logic [NSIDE-1:0]  irq_n;

   assign ctl[SIDE_L]  = '{sel: l_sel, we: l_we, busy: l_busy};
   assign ctl[SIDE_R]  = '{sel: r_sel, we: r_we, busy: r_busy};
   assign addr[SIDE_L] = l_addr;
   assign addr[SIDE_R] = r_addr;

   genvar s;
   generate
      for (s = 0; s < NSIDE; s++) begin : g_side
         localparam logic [ADDR_W-1:0] OWN  = (s == 0) ? BOX_L : BOX_R;
         localparam logic [ADDR_W-1:0] PEER = (s == 0) ? BOX_R : BOX_L;

         mbx_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_BOX  (OWN),
            .PEER_BOX (PEER)
         ) u_dec (
            .ctl_i        (ctl[s]),
            .addr_i       (addr[s]),
            .raise_peer_o (raise_from[s]),
            .drop_own_o   (drop_of[s])
         );

         mbx_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .raise_i (raise_from[peer_of(s)]),
            .drop_i  (drop_of[s]),
            .irq_n_o (irq_n[s])
         );
      end
   endgenerate

   assign l_irq_n = irq_n[SIDE_L];
   assign r_irq_n = irq_n[SIDE_R];

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (l_irq_n && r_irq_n));

   // R2
   r_raise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(r_irq_n) |-> $past(l_sel && l_we && (l_addr == BOX_R) && !l_busy));

   // R3
   l_raise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(l_irq_n) |-> $past(r_sel && r_we && (r_addr == BOX_L) && !r_busy));

   // R7
   l_drop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(l_irq_n) |-> $past(l_sel && !l_we && (l_addr == BOX_L) && !l_busy));

   // R7
   r_drop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(r_irq_n) |-> $past(r_sel && !r_we && (r_addr == BOX_R) && !r_busy));

endmodule

// File: tb/mbx_irq_ctrl_test.sv
module mbx_irq_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 13;
   localparam logic [AW-1:0] BR = 13'h1FFF;
   localparam logic [AW-1:0] BL = 13'h1FFE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_sel = 0, l_we = 0, l_busy = 0;
   logic r_sel = 0, r_we = 0, r_busy = 0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic l_irq_n, r_irq_n;

   int checks = 0;
   int errors = 0;
   logic pend_l = 0, pend_r = 0;
   logic [1:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_irq_ctrl #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n),
      .l_sel(l_sel), .l_we(l_we), .l_addr(l_addr), .l_busy(l_busy),
      .r_sel(r_sel), .r_we(r_we), .r_addr(r_addr), .r_busy(r_busy),
      .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
   );

   task automatic compare(input logic [1:0] exp, input string tag);
      checks++;
      if ({l_irq_n, r_irq_n} !== exp) begin
         errors++;
         $display("FAIL %s: {l_irq_n,r_irq_n} got %b expected %b", tag, {l_irq_n, r_irq_n}, exp);
      end
   endtask

   // driver: one cycle of stimulus, expected result pushed after the edge
   task automatic step(input logic ls, input logic lw, input logic [AW-1:0] la, input logic lb,
                       input logic rs, input logic rw, input logic [AW-1:0] ra, input logic rb,
                       input string tag);
      logic set_l, set_r, clr_l, clr_r;
      @(negedge clk);
      l_sel = ls; l_we = lw; l_addr = la; l_busy = lb;
      r_sel = rs; r_we = rw; r_addr = ra; r_busy = rb;
      set_r = ls && lw && la == BR && !lb;
      set_l = rs && rw && ra == BL && !rb;
      clr_l = ls && !lw && la == BL && !lb;
      clr_r = rs && !rw && ra == BR && !rb;
      if (set_l) pend_l = 1; else if (clr_l) pend_l = 0;
      if (set_r) pend_r = 1; else if (clr_r) pend_r = 0;
      @(posedge clk);
      exp_q.push_back({!pend_l, !pend_r});
      tag_q.push_back(tag);
   endtask

   // monitor: compares a quarter period after each edge
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      compare(2'b11, "R1 in reset");
      rst_n = 1'b1;
      step(0,0,0,0, 0,0,0,0, "R1 after reset");
      step(1,1,13'h0123,0, 1,0,13'h0010,0, "R10 other addresses");
      step(1,1,BR,0, 0,0,0,0, "R2 left writes right box");
      step(0,0,0,0, 0,0,0,0, "R11 hold");
      step(1,0,BR,0, 0,0,0,0, "R5 left reads right box");
      step(0,0,0,0, 1,0,BR,1, "R7 busy owner read");
      step(0,0,0,0, 1,1,BR,0, "R9 owner writes own box");
      step(0,0,0,0, 1,0,BR,0, "R4 right read clears");
      step(0,0,0,0, 1,1,BL,1, "R6 busy writer");
      step(0,0,0,0, 1,1,BL,0, "R3 right writes left box");
      step(0,0,0,0, 0,0,0,0, "R11 hold left");
      step(1,1,BL,0, 0,0,0,0, "R9 left writes own box");
      step(0,0,0,0, 1,0,BL,0, "R5 right reads left box");
      step(1,0,BL,0, 1,1,BL,0, "R8 raise beats clear left");
      step(1,0,BL,0, 0,0,0,0, "R4 left read clears");
      step(0,1,BR,0, 0,1,BL,0, "R10 strobes low");
      step(1,1,BR,0, 1,0,BR,0, "R8 raise beats clear right");
      step(0,0,0,0, 1,0,BR,0, "R4 right read clears again");
      step(1,1,BR,1, 0,0,0,0, "R6 busy left writer");
      step(1,1,BR,0, 1,1,BL,0, "R2 R3 both raised");
      step(1,0,BL,1, 1,0,BR,1, "R7 both busy reads");
      step(1,0,BL,0, 1,0,BR,0, "R4 both cleared");
      step(0,0,0,0, 0,0,0,0, "R11 idle end");
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule